// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a short run of the instruction stream ready for an execution stage. It owns a fetch address counter and reads ahead from memory whenever the bus is idle and the queue has room. The bytes land in a six-entry byte ring, and a byte-wide consumer port drains them in program order. Fetching and draining run at the same time, so memory reads happen while the execution side is still working on earlier bytes.

The bytes are fetched on speculation. When the execution side takes a control transfer, it raises a redirect carrying the target address. The queue then throws away every byte it holds and drops any read still in flight. Fetching restarts at the target. The head address output always gives the address of the byte that the consumer will take next.

Top module: `ifq_prefetch`

## Requirements
- R1: While reset is low and in the first cycle after it, `out_valid` is low, and both `out_addr` and `mem_addr` equal `boot_addr`.
- R2: The queue never holds more than DEPTH (6) bytes. When it is full and no read is outstanding, `mem_req` stays low.
- R3: A word read (`mem_wide`=1) is requested only at an even fetch address and only with at least two bytes free. The byte at the even address returns on `mem_rdata[7:0]` and the next byte on `mem_rdata[15:8]`. With an even address and one byte free, no request is made.
- R4: At an odd fetch address the fetcher requests a single-byte read (`mem_wide`=0) whenever at least one byte is free. That byte returns on `mem_rdata[15:8]`, and the next fetch address is even.
- R5: At most one read is outstanding. `mem_req` is raised only when no read is outstanding. It is held with a stable `mem_addr` until `mem_gnt` is high. A grant advances the fetch address by 2 for a word read and by 1 for a byte read.
- R6: While `out_valid` is high, `out_byte` is the memory byte at `out_addr`. A pop advances `out_addr` by one, and bytes come out in address order.
- R7: `out_valid` is low while the queue is empty. A pop while empty leaves `out_addr` unchanged.
- R8: `redir_valid` takes priority over a pop or a push in the same cycle, and `mem_req` is low in that cycle. In the next cycle the queue is empty, and `out_addr` and `mem_addr` equal the redirect address.
- R9: A read response that is outstanding at a redirect, or that arrives in the redirect cycle, is discarded and never reaches the consumer.
- R10: A push from a read response and a pop in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| boot_addr | input | 16 | Fetch and head address loaded by reset |
| mem_req | output | 1 | Read request valid |
| mem_addr | output | 16 | Read address (the fetch counter) |
| mem_wide | output | 1 | 1 = two-byte read, 0 = one-byte read |
| mem_gnt | input | 1 | Request accepted in this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data, byte lanes by address |
| out_valid | output | 1 | Queue holds at least one byte |
| out_byte | output | 8 | Byte at the queue head |
| out_addr | output | 16 | Address of the head byte |
| out_pop | input | 1 | Consume the head byte |
| redir_valid | input | 1 | Control transfer: flush and restart |
| redir_addr | input | 16 | Target address of the transfer |

## Verification
A grant and a redirect take effect at the next clock edge. So `mem_addr`, `out_addr` and the empty state are checked one cycle after the stimulus. A response raised in one cycle makes `out_valid` high one cycle later. A pop moves `out_addr` one cycle later. The bench drives inputs and samples outputs just after the falling edge. Its memory model answers a fixed, settable number of cycles after each grant. Every popped byte is compared against a scoreboard of expected addresses. The driver refills that scoreboard at each redirect, so a discarded or misplaced response shows up as a mismatch on the first byte it affects.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
  // state of the single outstanding memory read
  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_BYTE = 2'd1,
    RD_WORD = 2'd2
  } rd_state_e;

  // number of bytes entering the ring in one cycle
  localparam logic [1:0] PUSH_NONE = 2'd0;
  localparam logic [1:0] PUSH_ONE  = 2'd1;
  localparam logic [1:0] PUSH_TWO  = 2'd2;
endpackage

// File: rtl/ifq_store.sv
module ifq_store #(
  parameter int DEPTH  = 6,
  parameter int DATA_W = 8,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [1:0]        push_n,
  input  logic [DATA_W-1:0] push_b0,
  input  logic [DATA_W-1:0] push_b1,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [LVL_W-1:0]  level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d, wr_p1;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic [DATA_W-1:0] slot_q [DEPTH];
  logic              do_pop;
  logic [1:0]        do_push;

  always_comb begin
    do_pop  = pop && (lvl_q != '0) && !flush;
    do_push = flush ? 2'd0 : push_n;
    wr_p1   = step(wr_q);
    wr_d    = wr_q;
    rd_d    = rd_q;
    lvl_d   = lvl_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      lvl_d = '0;
    end else begin
      if (do_push == ifq_pkg::PUSH_ONE) wr_d = wr_p1;
      else if (do_push == ifq_pkg::PUSH_TWO) wr_d = step(wr_p1);
      if (do_pop) rd_d = step(rd_q);
      lvl_d = lvl_q + LVL_W'(do_push) - LVL_W'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic we0, we1;
    always_comb begin
      we0 = (do_push != ifq_pkg::PUSH_NONE) && (wr_q == PTR_W'(i));
      we1 = (do_push == ifq_pkg::PUSH_TWO) && (wr_p1 == PTR_W'(i));
    end
    always_ff @(posedge clk) begin
      if (we0)      slot_q[i] <= push_b0;
      else if (we1) slot_q[i] <= push_b1;
    end
  end

  assign head  = slot_q[rd_q];
  assign level = lvl_q;
endmodule

// File: rtl/ifq_fetch.sv
module ifq_fetch #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 6,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   boot_addr,
  input  logic                flush,
  input  logic [ADDR_W-1:0]   flush_addr,
  input  logic [LVL_W-1:0]    level,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_wide,
  input  logic                mem_gnt,
  input  logic                mem_rvalid,
  input  logic [2*DATA_W-1:0] mem_rdata,
  output logic [1:0]          push_n,
  output logic [DATA_W-1:0]   push_b0,
  output logic [DATA_W-1:0]   push_b1
);
  import ifq_pkg::*;

  rd_state_e         st_q, st_d;
  logic              disc_q, disc_d;
  logic [ADDR_W-1:0] fptr_q, fptr_d;
  logic [LVL_W-1:0]  free;
  logic              room;

  always_comb begin
    free     = LVL_W'(DEPTH) - level;
    room     = fptr_q[0] ? (free >= LVL_W'(1)) : (free >= LVL_W'(2));
    mem_wide = !fptr_q[0];
    mem_addr = fptr_q;
    mem_req  = (st_q == RD_IDLE) && !flush && room;
  end

  always_comb begin
    st_d    = st_q;
    disc_d  = disc_q;
    fptr_d  = fptr_q;
    push_n  = PUSH_NONE;
    push_b0 = mem_rdata[DATA_W-1:0];
    push_b1 = mem_rdata[2*DATA_W-1:DATA_W];
    if ((st_q != RD_IDLE) && mem_rvalid) begin
      st_d   = RD_IDLE;
      disc_d = 1'b0;
      if (!disc_q && !flush) begin
        if (st_q == RD_WORD) begin
          push_n = PUSH_TWO;
        end else begin
          push_n  = PUSH_ONE;
          push_b0 = mem_rdata[2*DATA_W-1:DATA_W];
        end
      end
    end
    if (mem_req && mem_gnt) begin
      st_d   = mem_wide ? RD_WORD : RD_BYTE;
      fptr_d = fptr_q + (mem_wide ? ADDR_W'(2) : ADDR_W'(1));
    end
    if (flush) begin
      fptr_d = flush_addr;
      if ((st_q != RD_IDLE) && !mem_rvalid) disc_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RD_IDLE;
      disc_q <= 1'b0;
      fptr_q <= boot_addr;
    end else begin
      st_q   <= st_d;
      disc_q <= disc_d;
      fptr_q <= fptr_d;
    end
  end
endmodule

// File: rtl/ifq_prefetch.sv
module ifq_prefetch #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   boot_addr,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_wide,
  input  logic                mem_gnt,
  input  logic                mem_rvalid,
  input  logic [2*DATA_W-1:0] mem_rdata,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_byte,
  output logic [ADDR_W-1:0]   out_addr,
  input  logic                out_pop,
  input  logic                redir_valid,
  input  logic [ADDR_W-1:0]   redir_addr
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [LVL_W-1:0]  level_w;
  logic [1:0]        push_n_w;
  logic [DATA_W-1:0] push_b0_w, push_b1_w;
  logic [ADDR_W-1:0] ip_q, ip_d;

  ifq_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .boot_addr  (boot_addr),
    .flush      (redir_valid),
    .flush_addr (redir_addr),
    .level      (level_w),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_wide   (mem_wide),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .push_n     (push_n_w),
    .push_b0    (push_b0_w),
    .push_b1    (push_b1_w)
  );

  ifq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (redir_valid),
    .push_n  (push_n_w),
    .push_b0 (push_b0_w),
    .push_b1 (push_b1_w),
    .pop     (out_pop),
    .head    (out_byte),
    .level   (level_w)
  );

  always_comb begin
    out_valid = (level_w != '0);
    ip_d      = ip_q;
    if (redir_valid)                ip_d = redir_addr;
    else if (out_pop && out_valid)  ip_d = ip_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ip_q <= boot_addr;
    else        ip_q <= ip_d;
  end

  assign out_addr = ip_q;
endmodule

// File: rtl/ifq_prefetch_chk.sv
module ifq_prefetch_chk #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 6,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_wide,
  input logic              mem_gnt,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_pop,
  input logic              redir_valid,
  input logic [ADDR_W-1:0] redir_addr,
  input logic [LVL_W-1:0]  level
);
  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  a_r3_word_room: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_wide) |-> (!mem_addr[0] && (LVL_W'(DEPTH) - level >= LVL_W'(2))));

  a_r4_odd_is_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_addr[0]) |-> !mem_wide);

  a_r5_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !redir_valid) |=>
      (redir_valid || (mem_req && mem_addr == $past(mem_addr))));

  a_r6_pop_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_pop && !redir_valid) |=> (out_addr == $past(out_addr) + ADDR_W'(1)));

  a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !redir_valid) |=> (out_addr == $past(out_addr)));

  a_r8_no_req_on_redir: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> !mem_req);

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (!out_valid && out_addr == $past(redir_addr) && mem_addr == $past(redir_addr)));
endmodule

bind ifq_prefetch ifq_prefetch_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr),
  .mem_wide    (mem_wide),
  .mem_gnt     (mem_gnt),
  .out_valid   (out_valid),
  .out_addr    (out_addr),
  .out_pop     (out_pop),
  .redir_valid (redir_valid),
  .redir_addr  (redir_addr),
  .level       (level_w)
);

// File: tb/ifq_prefetch_tb_top.sv
module ifq_prefetch_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] boot_addr;
  logic        mem_req, mem_wide, mem_gnt, mem_rvalid;
  logic [15:0] mem_addr, mem_rdata;
  logic        out_valid, out_pop, redir_valid;
  logic [7:0]  out_byte;
  logic [15:0] out_addr, redir_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // memory model state
  int          lat = 2;
  bit          gnt_en = 1'b1;
  bit          pend = 1'b0;
  int          lat_cnt = 0;
  logic [15:0] pend_addr;
  logic        pend_wide;
  bit          granted_now = 1'b0;

  logic [15:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ifq_prefetch dut_i (
    .clk(clk), .rst_n(rst_n), .boot_addr(boot_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wide(mem_wide),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_byte(out_byte), .out_addr(out_addr),
    .out_pop(out_pop), .redir_valid(redir_valid), .redir_addr(redir_addr)
  );

  function automatic logic [7:0] mbyte(input logic [15:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // driver: load the scoreboard with the byte addresses expected from a start point
  task automatic expect_from(input logic [15:0] a);
    exp_q.delete();
    for (int i = 0; i < 400; i++) exp_q.push_back(a + 16'(i));
  endtask

  // one cycle: inputs, memory model, then the pop monitor
  task automatic tick(input bit pop, input bit rd, input logic [15:0] ra);
    @(negedge clk);
    out_pop     = pop;
    redir_valid = rd;
    redir_addr  = ra;
    if (rd) expect_from(ra);
    mem_rvalid  = 1'b0;
    mem_gnt     = 1'b0;
    granted_now = 1'b0;
    if (pend) begin
      if (lat_cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = pend_wide ? {mbyte(pend_addr + 16'd1), mbyte(pend_addr)}
                               : {mbyte(pend_addr), 8'hEE};
        pend = 1'b0;
      end else begin
        lat_cnt--;
      end
    end
    #1;
    if (mem_req && gnt_en && !pend) begin
      mem_gnt     = 1'b1;
      pend        = 1'b1;
      lat_cnt     = lat - 1;
      pend_addr   = mem_addr;
      pend_wide   = mem_wide;
      granted_now = 1'b1;
    end
    if (pop && out_valid && !rd) begin
      // monitor: compare the popped byte against the scoreboard head (R6, R9, R10)
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 scoreboard empty", 32'(out_addr), 32'hFFFF);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(out_addr == e, "R6 head address", 32'(out_addr), 32'(e));
        chk(out_byte == mbyte(e), "R9 head byte", 32'(out_byte), 32'(mbyte(e)));
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; boot_addr = 16'h1000;
    out_pop = 1'b0; redir_valid = 1'b0; redir_addr = '0;
    mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 empty in reset", 32'(out_valid), 0);
    chk(out_addr == 16'h1000, "R1 head addr in reset", 32'(out_addr), 32'h1000);
    rst_n = 1'b1;
    expect_from(16'h1000);
    tick(0, 0, 0);
    chk(mem_req && mem_addr == 16'h1000 && mem_wide, "R1 R3 first word read",
        {15'd0, mem_req, mem_addr}, {15'd0, 1'b1, 16'h1000});
    chk(out_valid == 1'b0, "R1 empty after reset", 32'(out_valid), 0);

    // fill to full with no pops
    repeat (20) tick(0, 0, 0);
    chk(out_valid == 1'b1, "R2 full valid", 32'(out_valid), 1);
    chk(mem_req == 1'b0, "R2 full no request", 32'(mem_req), 0);
    chk(mem_addr == 16'h1006, "R5 fetch advanced by words", 32'(mem_addr), 32'h1006);

    // drain and refill concurrently
    for (int i = 0; i < 30; i++) tick(1, 0, 0);
    repeat (20) tick(0, 0, 0);

    // redirect to an odd address from a full, idle queue
    tick(0, 1, 16'h2001);
    tick(0, 0, 0);
    chk(out_valid == 1'b0, "R8 empty after redirect", 32'(out_valid), 0);
    chk(out_addr == 16'h2001, "R8 head addr", 32'(out_addr), 32'h2001);
    chk(mem_addr == 16'h2001 && mem_req && !mem_wide, "R4 odd byte read",
        {15'd0, mem_wide, mem_addr}, {15'd0, 1'b0, 16'h2001});
    repeat (20) tick(0, 0, 0);
    chk(mem_req == 1'b0 && mem_addr == 16'h2006, "R3 one free even no read",
        {15'd0, mem_req, mem_addr}, {15'd0, 1'b0, 16'h2006});
    tick(1, 0, 0);
    tick(0, 0, 0);
    chk(mem_req && mem_wide && mem_addr == 16'h2006, "R3 word after pop",
        {15'd0, mem_wide, mem_addr}, {15'd0, 1'b1, 16'h2006});
    for (int i = 0; i < 40; i++) tick(1, 0, 0);

    // redirect with a same-cycle pop, then pop while empty
    tick(1, 1, 16'h3000);
    tick(1, 0, 0);
    tick(1, 0, 0);
    chk(out_addr == 16'h3000, "R7 pop on empty ignored", 32'(out_addr), 32'h3000);
    for (int i = 0; i < 30; i++) tick(1, 0, 0);

    // grant stall: request held with stable address
    repeat (10) tick(0, 0, 0);
    tick(1, 0, 0);
    tick(1, 0, 0);
    gnt_en = 1'b0;
    tick(0, 0, 0);
    begin
      logic [15:0] held;
      held = mem_addr;
      chk(mem_req == 1'b1, "R5 request raised", 32'(mem_req), 1);
      tick(0, 0, 0);
      tick(0, 0, 0);
      chk(mem_req && mem_addr == held, "R5 request held", 32'(mem_addr), 32'(held));
    end
    gnt_en = 1'b1;
    for (int i = 0; i < 20; i++) tick(1, 0, 0);

    // redirect while a slow read is outstanding
    lat = 4;
    begin
      int guard = 0;
      do begin tick(1, 0, 0); guard++; end while (!granted_now && guard < 50);
    end
    tick(0, 1, 16'h5000);
    for (int i = 0; i < 40; i++) tick(1, 0, 0);

    // redirect in the cycle the response arrives
    lat = 2;
    begin
      int guard = 0;
      do begin tick(1, 0, 0); guard++; end while (!granted_now && guard < 50);
    end
    tick(1, 0, 0);
    tick(0, 1, 16'h6123);
    tick(0, 0, 0);
    chk(out_valid == 1'b0, "R9 same-cycle response dropped", 32'(out_valid), 0);
    for (int i = 0; i < 40; i++) tick(1, 0, 0);
    chk(checks > 100, "R10 stream progressed", 32'(checks), 100);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule